// File: doc/BRIEF.md
# Paged Word-Address Counter with Half-Array Write Lock

This block keeps the internal word address of a 512-byte serial memory and enforces the access rules around it. A serial protocol engine drives it with single-cycle strobes:

- **Address load.** Takes the page bit from the select byte and the eight bits of the word-address byte.
- **Byte write.** Puts a received data byte into a 16-entry page latch at the current in-page offset. Each latch slot has its own valid bit.
- **Byte read.** Fetches the byte at the current address from the array.
- **Commit.** Sent when the stop condition of a write ends the transfer. It copies the valid latch slots into the array in one cycle.

The counter moves differently for the two directions. Writes advance only the four offset bits, so a burst stays inside its 16-byte page. Reads advance all nine bits, so a read stream runs through the whole array. When no strobe arrives the counter holds, so a later current-address read continues from the byte after the last one touched.

A protect input guards the upper half of the array, addresses 256 to 511. While protect is high, bytes aimed there are still taken into the latch and the counter still advances. The commit, however, leaves those array bytes unchanged. The lower half stays writable in every case. The array is a synchronous RAM model whose read data appears one clock after the read strobe.

Top module: `paged_addr_ctl`

## Requirements
- R1: After reset, `addr_o` is 0 and `rd_data_o` is 0. The page latch holds no valid bytes, and every array byte reads as 0.
- R2: An `ld_i` strobe sets `addr_o` to {`ld_page_i`, `ld_word_i`} on the next cycle. `ld_page_i` is address bit 8.
- R3: Each `wr_i` strobe stores `wr_data_i` in the latch slot given by `addr_o[3:0]` and then adds 1 to `addr_o[3:0]` modulo 16. `addr_o[8:4]` stays unchanged. The 17th byte of a burst therefore replaces the first.
- R4: A commit writes only the latch slots filled since the last load or commit. The other bytes of the page keep their old contents.
- R5: Each `rd_i` strobe adds 1 to the full 9-bit `addr_o`, so 511 is followed by 0.
- R6: With no strobe, `addr_o` holds its value. A read without a new load returns the byte at the held address.
- R7: With `protect_i` high at the commit, a page in 256..511 keeps its array contents. The write strobes are still accepted: the counter advances as in R3. Pages in 0..255 commit normally.
- R8: With `protect_i` low, a commit to any page, including 256..511, updates the array.
- R9: `rd_data_o` shows the byte at the pre-strobe address one clock after the `rd_i` strobe. It then holds until the next read.
- R10: A load, and likewise a commit, empties the latch's valid set. Bytes written before a reload are never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Address load strobe |
| ld_page_i | input | 1 | Page bit from the select byte (address bit 8) |
| ld_word_i | input | 8 | Word-address byte (address bits 7..0) |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Data byte for the write strobe |
| rd_i | input | 1 | Byte read strobe |
| commit_i | input | 1 | Commit the page latch into the array |
| protect_i | input | 1 | High locks the upper half of the array |
| rd_data_o | output | 8 | Read data, valid one clock after `rd_i` |
| addr_o | output | 9 | Current internal word address |

## Verification
The embedded properties assume that the protocol engine raises at most one of `ld_i`, `wr_i`, `rd_i` and `commit_i` in any cycle. They also assume that a commit never coincides with a byte write. The directed bench keeps to this by having each task assert a single strobe for one cycle and release it before the next task starts. The bench also holds `protect_i` steady around each commit, because the lock is judged only in the commit cycle.

// File: rtl/pac_pkg.sv
package pac_pkg;
  parameter int ADDR_W = 9;
  parameter int OFF_W  = 4;
  parameter int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PAGE_B = 1 << OFF_W;

  // next address after a byte write: offset wraps inside the page
  function automatic logic [ADDR_W-1:0] wr_next(input logic [ADDR_W-1:0] a);
    logic [OFF_W-1:0] off;
    off = OFF_W'(a[OFF_W-1:0] + 1'b1);
    return {a[ADDR_W-1:OFF_W], off};
  endfunction

  // next address after a byte read: whole array wraps
  function automatic logic [ADDR_W-1:0] rd_next(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  // page lies in the locked upper half while protection is on
  function automatic logic page_locked(input logic [PAGE_W-1:0] pg, input logic prot);
    return prot & pg[PAGE_W-1];
  endfunction
endpackage

// File: rtl/pac_counter.sv
module pac_counter
  import pac_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load_i)    addr_d = load_addr_i;
    else if (wr_i) addr_d = wr_next(addr_q);
    else if (rd_i) addr_d = rd_next(addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(load_addr_i)); // R2
  AST_WR_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !load_i) |=> addr_o[AW-1:OFF_W] == $past(addr_o[AW-1:OFF_W])); // R3
  AST_WR_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !load_i) |=> addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0]) + 1)); // R3
  AST_RD_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !load_i && !wr_i) |=> addr_o == AW'($past(addr_o) + 1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wr_i && !rd_i) |=> $stable(addr_o)); // R6
endmodule

// File: rtl/pac_latch.sv
module pac_latch
  import pac_pkg::*;
#(
  parameter int OW = OFF_W,
  parameter int DW = DATA_W,
  localparam int NB = 1 << OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           commit_i,
  input  logic           wr_i,
  input  logic [OW-1:0]  off_i,
  input  logic [DW-1:0]  data_i,
  output logic [NB-1:0]  mask_o,
  output logic [NB*DW-1:0] data_o
);
  logic [NB-1:0] mask_q;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic          hit;
    logic [DW-1:0] byte_q;
    assign hit = wr_i && !clear_i && (off_i == OW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q[l] <= 1'b0;
      else if (clear_i || commit_i)    mask_q[l] <= 1'b0;
      else if (hit)                    mask_q[l] <= 1'b1;
    end
    assign data_o[l*DW +: DW] = byte_q;
  end

  assign mask_o = mask_q;

  AST_MASK_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> mask_o == '0); // R10
  AST_MASK_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> mask_o == '0); // R10
  AST_MASK_SETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clear_i && !commit_i) |=> mask_o[$past(off_i)]); // R3
endmodule

// File: rtl/pac_ram.sv
module pac_ram
  import pac_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int DW = DATA_W,
  localparam int PW = AW - OW,
  localparam int NB = 1 << OW,
  localparam int DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [PW-1:0]  page_i,
  input  logic [NB-1:0]  mask_i,
  input  logic [NB*DW-1:0] wdata_i,
  input  logic           re_i,
  input  logic [AW-1:0]  raddr_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < NB; l++)
        if (mask_i[l]) mem[{page_i, OW'(l)}] <= wdata_i[l*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/paged_addr_ctl.sv
module paged_addr_ctl
  import pac_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int DW = DATA_W,
  localparam int PW = AW - OW,
  localparam int NB = 1 << OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          ld_page_i,
  input  logic [AW-2:0] ld_word_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  input  logic          commit_i,
  input  logic          protect_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0]    load_addr;
  logic [AW-1:0]    cur_addr;
  logic [PW-1:0]    wpage_q;
  logic [NB-1:0]    lat_mask;
  logic [NB*DW-1:0] lat_data;
  logic             commit_blocked;
  logic             ram_we;

  assign load_addr = {ld_page_i, ld_word_i};

  pac_counter #(.AW(AW)) u_cnt (
    .clk, .rst_n,
    .load_i(ld_i), .load_addr_i(load_addr),
    .wr_i, .rd_i,
    .addr_o(cur_addr)
  );

  // page targeted by the pending burst, fixed at each load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wpage_q <= '0;
    else if (ld_i) wpage_q <= load_addr[AW-1:OW];
  end

  pac_latch #(.OW(OW), .DW(DW)) u_lat (
    .clk, .rst_n,
    .clear_i(ld_i), .commit_i,
    .wr_i, .off_i(cur_addr[OW-1:0]), .data_i(wr_data_i),
    .mask_o(lat_mask), .data_o(lat_data)
  );

  assign commit_blocked = commit_i && page_locked(wpage_q, protect_i);
  assign ram_we         = commit_i && !commit_blocked;

  pac_ram #(.AW(AW), .OW(OW), .DW(DW)) u_ram (
    .clk, .rst_n,
    .we_i(ram_we), .page_i(wpage_q), .mask_i(lat_mask), .wdata_i(lat_data),
    .re_i(rd_i), .raddr_i(cur_addr), .rdata_o(rd_data_o)
  );

  assign addr_o = cur_addr;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld_i, wr_i, rd_i, commit_i}) <= 1); // R6
  AST_BURST_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ld_i) |-> cur_addr[AW-1:OW] == wpage_q); // R3
endmodule

// File: tb/tb_paged_addr_ctl.sv
module tb_paged_addr_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_i = 0, ld_page_i = 0, wr_i = 0, rd_i = 0, commit_i = 0, protect_i = 0;
  logic [7:0] ld_word_i = '0, wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [8:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] exp_mem [512];
  logic [7:0] exp_lat [16];
  logic [15:0] exp_msk;
  logic [4:0] exp_pg;
  logic [8:0] exp_addr;

  always #2.5 clk = ~clk;

  paged_addr_ctl dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [8:0] a);
    @(negedge clk); ld_i = 1; ld_page_i = a[8]; ld_word_i = a[7:0];
    @(negedge clk); ld_i = 0;
    exp_addr = a; exp_pg = a[8:4]; exp_msk = '0;
    chk("R2 load", addr_o, a);
  endtask

  task automatic do_wr(logic [7:0] d);
    @(negedge clk); wr_i = 1; wr_data_i = d;
    @(negedge clk); wr_i = 0;
    exp_lat[exp_addr[3:0]] = d; exp_msk[exp_addr[3:0]] = 1'b1;
    exp_addr = {exp_addr[8:4], 4'(exp_addr[3:0] + 1)};
    chk("R3 write step", addr_o, exp_addr);
  endtask

  task automatic do_commit();
    @(negedge clk); commit_i = 1;
    @(negedge clk); commit_i = 0;
    if (!(protect_i && exp_pg[4]))
      for (int l = 0; l < 16; l++)
        if (exp_msk[l]) exp_mem[{exp_pg, 4'(l)}] = exp_lat[l];
    exp_msk = '0;
  endtask

  task automatic do_rd(string req);
    logic [7:0] e;
    e = exp_mem[exp_addr];
    @(negedge clk); rd_i = 1;
    @(negedge clk); rd_i = 0;
    exp_addr = 9'(exp_addr + 1);
    chk({req, " R9 data"}, rd_data_o, e);
    chk("R5 read step", addr_o, exp_addr);
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_o, 0);
    chk("R1 rdata", rd_data_o, 0);
    do_load(9'h1A7); do_rd("R1 array");
  endtask

  task automatic t_burst_wrap();
    do_load(9'h0ED);
    for (int i = 0; i < 18; i++) do_wr(8'h50 + 8'(i));
    do_commit();
    do_load(9'h0E0);
    for (int i = 0; i < 16; i++) do_rd("R3 page wrap");
  endtask

  task automatic t_partial();
    do_load(9'h045);
    for (int i = 0; i < 3; i++) do_wr(8'hA0 + 8'(i));
    do_commit();
    do_load(9'h040);
    for (int i = 0; i < 16; i++) do_rd("R4 partial");
  endtask

  task automatic t_read_wrap();
    exp_mem[9'h1FF] = 8'h00;
    do_load(9'h1FE);
    for (int i = 0; i < 3; i++) do_rd("R5 wrap");
    chk("R5 wrap addr", addr_o, 9'h001);
  endtask

  task automatic t_hold();
    do_load(9'h0E4);
    do_rd("R6 pre");
    repeat (5) @(negedge clk);
    chk("R6 hold", addr_o, 9'h0E5);
    do_rd("R6 current read");
  endtask

  task automatic t_protect();
    protect_i = 1;
    do_load(9'h123);
    for (int i = 0; i < 4; i++) do_wr(8'hC0 + 8'(i));
    chk("R7 counter advances", addr_o, 9'h127);
    do_commit();
    do_load(9'h123);
    for (int i = 0; i < 4; i++) do_rd("R7 locked");
    do_load(9'h030);
    do_wr(8'h77); do_wr(8'h78);
    do_commit();
    do_load(9'h030);
    do_rd("R7 lower half"); do_rd("R7 lower half");
    protect_i = 0;
  endtask

  task automatic t_unprotected();
    do_load(9'h1F8);
    for (int i = 0; i < 3; i++) do_wr(8'h3C + 8'(i));
    do_commit();
    do_load(9'h1F8);
    for (int i = 0; i < 3; i++) do_rd("R8 upper write");
  endtask

  task automatic t_reload_drops();
    do_load(9'h060);
    do_wr(8'h11); do_wr(8'h22);
    do_load(9'h070);
    do_wr(8'h33);
    do_commit();
    do_load(9'h060);
    do_rd("R10 dropped"); do_rd("R10 dropped");
    do_load(9'h070);
    do_rd("R10 kept");
    do_commit();
    do_load(9'h071);
    do_rd("R10 empty after commit");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = '0;
    for (int i = 0; i < 16; i++) exp_lat[i] = '0;
    exp_msk = '0; exp_pg = '0; exp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_burst_wrap();
    t_partial();
    t_read_wrap();
    t_hold();
    t_protect();
    t_unprotected();
    t_reload_drops();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule